// File: doc/BRIEF.md
# ADC Power-Mode Control Sequencer

This block is the digital power manager of a serial converter. It samples two pins, a serial bit clock (`adc_clk`) and a conversion strobe (`conv`), with the system clock. From them it keeps track of whether the converter is running, napping, asleep or on its way back. While the bit clock rests low, strobe pulses are counted. The falling edge of the second pulse drops the converter into nap. The falling edge of the fourth pulse drops it into sleep, which also powers the reference down and clears the reference-ready flag.

A rising edge on the bit clock starts recovery. From nap, the block sits in a waking state for a fixed number of system cycles and then returns to active. From sleep, it behaves as if napping and keeps the ready flag low for a longer settling count. When that count ends it raises the flag and goes straight to active. Each strobe rising edge requests a conversion. On the following bit-clock rising edges the serial output carries a 13-bit frame: a ready bit, then the 12-bit sample MSB first. The frame is all zeros whenever the converter was not active with a settled reference when the request arrived. With no request pending, the output is released (`dout_oe` low, modelling high impedance). The sample value comes in on a port; analog behaviour is outside the block.

Internal states are ACTIVE, NAP, SLEEP, WAKE (leaving nap) and REFSET (leaving sleep). The transitions are as follows. ACTIVE goes to NAP on the second pulse and to SLEEP on the fourth. NAP goes to WAKE on a clock rise and to SLEEP on the fourth pulse. WAKE goes to ACTIVE when its count expires, or back to NAP or SLEEP on pulses. SLEEP goes to REFSET on a clock rise. REFSET goes to ACTIVE when settling ends and to SLEEP on the fourth pulse.

Top module: `adc_pm_seq`

## Requirements
- R1: After reset the status is ACTIVE (`pwr_status` = 2'b00), `ref_ready` is 1 and `dout_oe` is 0.
- R2: Two `conv` pulses while `adc_clk` stays low switch the status to NAP (2'b01) on the falling edge of the second pulse; after the first pulse the status is unchanged.
- R3: Four `conv` pulses while `adc_clk` stays low switch the status to SLEEP (2'b10) on the falling edge of the fourth pulse and clear `ref_ready`.
- R4: The pulse count restarts whenever `adc_clk` is high. A single pulse, or pulses separated by a bit-clock rise, changes no state. A third pulse leaves the block in NAP.
- R5: An `adc_clk` rise in NAP gives status WAKING (2'b11) for exactly NAP_WAKE_CYC system cycles, then ACTIVE, with `ref_ready` held at 1.
- R6: An `adc_clk` rise in SLEEP gives status NAP with `ref_ready` at 0 for exactly REF_SETTLE_CYC system cycles. After that, `ref_ready` rises to 1 and the status becomes ACTIVE in the same cycle.
- R7: A `conv` rise in ACTIVE with `ref_ready` set loads the frame {1, sample_data}. The next 13 `adc_clk` rises drive its bits MSB first with `dout_oe` high, and the 14th rise releases `dout_oe`.
- R8: A `conv` rise in any state other than ACTIVE with `ref_ready` set loads a frame of 13 zero bits, shifted out the same way.
- R9: With no conversion pending, `dout_oe` and `dout` stay 0 however `adc_clk` toggles.
- R10: A `conv` rise while a frame is pending or shifting does not restart it, and the remaining bits keep the word captured at the first rise.
- R11: Entering NAP or SLEEP discards any pending or shifting frame, so `dout_oe` is 0 and the next `adc_clk` rise drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_clk | input | 1 | Serial bit clock pin, sampled by `clk` |
| conv | input | 1 | Conversion / power-down strobe pin, sampled by `clk` |
| sample_data | input | DATA_W | Conversion result captured on a request |
| dout | output | 1 | Serial frame bit |
| dout_oe | output | 1 | Output drive enable; 0 models high impedance |
| ref_ready | output | 1 | Reference-settled flag |
| pwr_status | output | 2 | 00 active, 01 nap, 10 sleep, 11 waking |

## Verification
Each pin goes through two sampling registers before a state register or a shift register reacts. Every result therefore appears after the second system clock rising edge that follows a pin change. The bench changes pins on a falling edge, waits two rising edges and samples on the next falling edge. Recovery windows are checked in their last cycle and again in the first cycle after they end, so a count that is off by one in either direction is caught. Frames are read one bit per `adc_clk` rise, compared against a word the bench builds from the state it expects when the request was made.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;

    typedef enum logic [2:0] {
        S_ACTIVE,
        S_NAP,
        S_SLEEP,
        S_WAKE,
        S_REFSET
    } pm_state_e;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'b00,
        PS_NAP    = 2'b01,
        PS_SLEEP  = 2'b10,
        PS_WAKING = 2'b11
    } pm_status_e;

    localparam int NAP_PULSES   = 2;
    localparam int SLEEP_PULSES = 4;

endpackage

// File: rtl/pm_pin_edge.sv
module pm_pin_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] lvl,
    output logic [N-1:0] lvl_d
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl[g]   <= 1'b0;
                lvl_d[g] <= 1'b0;
            end else begin
                lvl[g]   <= pins[g];
                lvl_d[g] <= lvl[g];
            end
        end
    end

endmodule

// File: rtl/pm_pulse_count.sv
module pm_pulse_count #(
    parameter int NAP_AT   = 2,
    parameter int SLEEP_AT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_level,
    input  logic strobe_fall,
    output logic nap_hit,
    output logic sleep_hit
);

    localparam int CNT_W = $clog2(SLEEP_AT + 2);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] NAP_PRE   = CNT_W'(NAP_AT - 1);
    localparam logic [CNT_W-1:0] SLEEP_PRE = CNT_W'(SLEEP_AT - 1);

    logic [CNT_W-1:0] cnt;
    logic             counting;

    assign counting  = strobe_fall && !clk_level;
    assign nap_hit   = counting && (cnt == NAP_PRE);
    assign sleep_hit = counting && (cnt == SLEEP_PRE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clk_level) begin
            cnt <= '0;
        end else if (counting && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    output logic         expired
);

    logic [W-1:0] cnt;
    logic         running;

    assign expired = running && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= load;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pm_frame_shift.sv
module pm_frame_shift #(
    parameter int FRAME_BITS = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic [FRAME_BITS-1:0] arm_word,
    input  logic                  cancel,
    input  logic                  tick,
    output logic                  dout,
    output logic                  oe,
    output logic                  busy
);

    localparam int IDX_W = $clog2(FRAME_BITS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS);

    logic [FRAME_BITS-1:0] word;
    logic [IDX_W-1:0]      idx;
    logic                  armed;

    assign busy = armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            idx   <= '0;
            armed <= 1'b0;
            dout  <= 1'b0;
            oe    <= 1'b0;
        end else if (cancel) begin
            armed <= 1'b0;
            idx   <= '0;
            dout  <= 1'b0;
            oe    <= 1'b0;
        end else if (arm && !armed) begin
            word  <= arm_word;
            idx   <= '0;
            armed <= 1'b1;
        end else if (tick && armed) begin
            if (idx < LAST_IDX) begin
                dout <= word[FRAME_BITS-1];
                word <= word << 1;
                oe   <= 1'b1;
                idx  <= idx + 1'b1;
            end else begin
                dout  <= 1'b0;
                oe    <= 1'b0;
                armed <= 1'b0;
                idx   <= '0;
            end
        end
    end

endmodule

// File: rtl/adc_pm_seq.sv
module adc_pm_seq
    import adc_pm_pkg::*;
#(
    parameter int DATA_W         = 12,
    parameter int NAP_WAKE_CYC   = 70,
    parameter int REF_SETTLE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adc_clk,
    input  logic              conv,
    input  logic [DATA_W-1:0] sample_data,
    output logic              dout,
    output logic              dout_oe,
    output logic              ref_ready,
    output logic [1:0]        pwr_status
);

    localparam int FRAME_BITS = DATA_W + 1;
    localparam int WAIT_MAX   = (REF_SETTLE_CYC > NAP_WAKE_CYC) ? REF_SETTLE_CYC : NAP_WAKE_CYC;
    localparam int TMR_W      = $clog2(WAIT_MAX + 1);
    localparam logic [TMR_W-1:0] NAP_LOAD = TMR_W'(NAP_WAKE_CYC - 1);
    localparam logic [TMR_W-1:0] REF_LOAD = TMR_W'(REF_SETTLE_CYC - 1);

    // pin sampling: bit 0 bit clock, bit 1 strobe
    logic [1:0] pin_now;
    logic [1:0] pin_prev;
    logic       bclk_level;
    logic       bclk_rise;
    logic       strobe_rise;
    logic       strobe_fall;

    pm_pin_edge #(.N(2)) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({conv, adc_clk}),
        .lvl   (pin_now),
        .lvl_d (pin_prev)
    );

    assign bclk_level  = pin_now[0];
    assign bclk_rise   = pin_now[0] & ~pin_prev[0];
    assign strobe_rise = pin_now[1] & ~pin_prev[1];
    assign strobe_fall = ~pin_now[1] & pin_prev[1];

    logic nap_hit;
    logic sleep_hit;

    pm_pulse_count #(
        .NAP_AT   (NAP_PULSES),
        .SLEEP_AT (SLEEP_PULSES)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_level   (bclk_level),
        .strobe_fall (strobe_fall),
        .nap_hit     (nap_hit),
        .sleep_hit   (sleep_hit)
    );

    logic             tmr_start;
    logic [TMR_W-1:0] tmr_load;
    logic             tmr_done;

    pm_settle_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .load    (tmr_load),
        .expired (tmr_done)
    );

    pm_state_e state;
    pm_state_e state_n;
    logic      go_low;
    logic      ref_set;

    // next state and recovery timer control
    always_comb begin
        state_n   = state;
        tmr_start = 1'b0;
        tmr_load  = '0;
        go_low    = 1'b0;
        ref_set   = 1'b0;
        unique case (state)
            S_ACTIVE: begin
                if (sleep_hit) begin
                    state_n = S_SLEEP;
                    go_low  = 1'b1;
                end else if (nap_hit) begin
                    state_n = S_NAP;
                    go_low  = 1'b1;
                end
            end
            S_NAP: begin
                if (sleep_hit) begin
                    state_n = S_SLEEP;
                    go_low  = 1'b1;
                end else if (bclk_rise) begin
                    state_n   = S_WAKE;
                    tmr_start = 1'b1;
                    tmr_load  = NAP_LOAD;
                end
            end
            S_WAKE: begin
                if (sleep_hit) begin
                    state_n = S_SLEEP;
                    go_low  = 1'b1;
                end else if (nap_hit) begin
                    state_n = S_NAP;
                    go_low  = 1'b1;
                end else if (tmr_done) begin
                    state_n = S_ACTIVE;
                end
            end
            S_SLEEP: begin
                if (bclk_rise) begin
                    state_n   = S_REFSET;
                    tmr_start = 1'b1;
                    tmr_load  = REF_LOAD;
                end
            end
            S_REFSET: begin
                if (sleep_hit) begin
                    state_n = S_SLEEP;
                    go_low  = 1'b1;
                end else if (tmr_done) begin
                    state_n = S_ACTIVE;
                    ref_set = 1'b1;
                end
            end
            default: begin
                state_n = S_ACTIVE;
            end
        endcase
    end

    // state register and reference flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_ACTIVE;
            ref_ready <= 1'b1;
        end else begin
            state <= state_n;
            if (go_low && (state_n == S_SLEEP)) begin
                ref_ready <= 1'b0;
            end else if (ref_set) begin
                ref_ready <= 1'b1;
            end
        end
    end

    // frame content chosen at the request
    logic                  live_frame;
    logic [FRAME_BITS-1:0] frame_word;

    assign live_frame = (state == S_ACTIVE) && ref_ready;
    assign frame_word = live_frame ? {1'b1, sample_data} : '0;

    pm_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (strobe_rise),
        .arm_word (frame_word),
        .cancel   (go_low),
        .tick     (bclk_rise),
        .dout     (dout),
        .oe       (dout_oe),
        .busy     ()
    );

    // status outputs
    always_comb begin
        unique case (state)
            S_ACTIVE: pwr_status = PS_ACTIVE;
            S_NAP:    pwr_status = PS_NAP;
            S_REFSET: pwr_status = PS_NAP;
            S_SLEEP:  pwr_status = PS_SLEEP;
            S_WAKE:   pwr_status = PS_WAKING;
            default:  pwr_status = PS_ACTIVE;
        endcase
    end

endmodule

// File: rtl/adc_pm_seq_chk.sv
module adc_pm_seq_chk
    import adc_pm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       dout,
    input logic       dout_oe,
    input logic       ref_ready,
    input logic [1:0] pwr_status
);

    AST_SLEEP_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_status == PS_SLEEP) |-> !ref_ready); // R3

    AST_ACTIVE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_status == PS_ACTIVE) |-> ref_ready); // R6

    AST_SLEEP_EXIT_NAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_status) == PS_SLEEP && pwr_status != PS_SLEEP) |-> (pwr_status == PS_NAP)); // R6

    AST_READY_RISE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ready) |-> (pwr_status == PS_ACTIVE)); // R6

    AST_WAKING_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_status == PS_WAKING) |-> ref_ready); // R5

    AST_ZERO_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && !ref_ready) |-> !dout); // R8

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout); // R9

    AST_SLEEP_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_status == PS_SLEEP) |-> !dout_oe); // R11

endmodule

bind adc_pm_seq adc_pm_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .ref_ready  (ref_ready),
    .pwr_status (pwr_status)
);

// File: tb/tb_adc_pm_seq.sv
`timescale 1ns/1ps
module tb_adc_pm_seq;

    localparam int DW   = 12;
    localparam int NAPC = 6;
    localparam int REFC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adc_clk = 1'b0;
    logic          conv = 1'b0;
    logic [DW-1:0] sample_data = '0;
    logic          dout;
    logic          dout_oe;
    logic          ref_ready;
    logic [1:0]    pwr_status;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_pm_seq #(
        .DATA_W         (DW),
        .NAP_WAKE_CYC   (NAPC),
        .REF_SETTLE_CYC (REFC)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .adc_clk     (adc_clk),
        .conv        (conv),
        .sample_data (sample_data),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .ref_ready   (ref_ready),
        .pwr_status  (pwr_status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive pins on a falling edge, result due after two rising edges
    task automatic apply(input logic c, input logic v);
        adc_clk = c;
        conv    = v;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        apply(1'b0, 1'b1);
        apply(1'b0, 1'b0);
    endtask

    function automatic logic [DW:0] exp_frame(input bit live, input logic [DW-1:0] d);
        return live ? {1'b1, d} : '0;
    endfunction

    function automatic logic [1:0] exp_status_after(input int k);
        if (k >= 4) return 2'b10;
        if (k >= 2) return 2'b01;
        return 2'b00;
    endfunction

    task automatic read_frame(input logic [DW:0] exp, input int poke_at,
                              input logic [DW-1:0] newdata, input string tag);
        for (int i = 0; i <= DW; i++) begin
            apply(1'b1, 1'b0);
            chk({tag, " oe"}, int'(dout_oe), 1);
            chk({tag, " bit"}, int'(dout), int'(exp[DW-i]));
            apply(1'b0, 1'b0);
            if (i == poke_at) begin
                sample_data = newdata;
                pulse();
            end
        end
        apply(1'b1, 1'b0);
        chk({tag, " release"}, int'(dout_oe), 0);
        apply(1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        void'($urandom(32'hC0FFEE));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk("R1 status", int'(pwr_status), 0);
        chk("R1 ready", int'(ref_ready), 1);
        chk("R1 oe", int'(dout_oe), 0);

        // R9 clock toggling alone drives nothing
        for (int i = 0; i < 5; i++) begin
            apply(1'b1, 1'b0);
            chk("R9 oe", int'(dout_oe), 0);
            chk("R9 dout", int'(dout), 0);
            apply(1'b0, 1'b0);
        end

        // R7 live frame, R10 mid-frame request ignored, R4 count restarts
        a = DW'($urandom);
        b = ~a;
        sample_data = a;
        pulse();
        chk("R4 one pulse", int'(pwr_status), 0);
        read_frame(exp_frame(1'b1, a), 5, b, "R7 R10 frame");
        chk("R4 split pulses", int'(pwr_status), 0);

        // R2 nap entry, R11 pending frame dropped, R5 wake window
        pulse();
        chk("R2 first pulse", int'(pwr_status), 0);
        pulse();
        chk("R2 nap", int'(pwr_status), 1);
        chk("R11 oe after nap", int'(dout_oe), 0);
        apply(1'b1, 1'b0);
        chk("R11 no drive on rise", int'(dout_oe), 0);
        chk("R5 waking", int'(pwr_status), 3);
        chk("R5 ready", int'(ref_ready), 1);
        idle(NAPC - 1);
        chk("R5 waking last", int'(pwr_status), 3);
        idle(1);
        chk("R5 active", int'(pwr_status), 0);
        apply(1'b0, 1'b0);

        // R3 sleep entry, R6 settle window
        for (int i = 0; i < 4; i++) pulse();
        chk("R3 sleep", int'(pwr_status), 2);
        chk("R3 ready low", int'(ref_ready), 0);
        apply(1'b1, 1'b0);
        chk("R6 auto nap", int'(pwr_status), 1);
        chk("R6 ready low", int'(ref_ready), 0);
        idle(REFC - 1);
        chk("R6 nap last", int'(pwr_status), 1);
        chk("R6 ready last", int'(ref_ready), 0);
        idle(1);
        chk("R6 active", int'(pwr_status), 0);
        chk("R6 ready", int'(ref_ready), 1);
        apply(1'b0, 1'b0);

        // R8 request while settling the reference
        for (int i = 0; i < 4; i++) pulse();
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b0);
        sample_data = DW'($urandom) | 1;
        pulse();
        read_frame('0, -1, '0, "R8 settle frame");
        idle(REFC);

        // R8 request while waking from nap
        pulse();
        pulse();
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b0);
        sample_data = '1;
        pulse();
        read_frame('0, -1, '0, "R8 wake frame");
        idle(NAPC);

        // random mix: pulse counts 0..5 then a live conversion
        for (int it = 0; it < 24; it++) begin
            int k;
            logic [DW-1:0] d;
            k = int'($urandom_range(0, 5));
            d = DW'($urandom);
            sample_data = d;
            for (int p = 0; p < k; p++) pulse();
            chk("R2 R3 R4 random status", int'(pwr_status), int'(exp_status_after(k)));
            if (k % 2 == 1) begin
                read_frame(exp_frame(k == 1, d), -1, '0, "R7 R8 R11 random pending");
            end else if (k != 0) begin
                apply(1'b1, 1'b0);
                apply(1'b0, 1'b0);
            end
            idle(REFC + NAPC + 10);
            chk("R6 random recovered", int'(pwr_status), 0);
            chk("R6 random ready", int'(ref_ready), 1);
            d = DW'($urandom);
            sample_data = d;
            pulse();
            read_frame(exp_frame(1'b1, d), -1, '0, "R7 random frame");
            idle(int'($urandom_range(0, 7)));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule